// File: doc/BRIEF.md
# Audio sample FIFO pair with DMA threshold requests

This block sits between a bus or DMA master and a serial audio engine. It holds two sample queues of 32 entries each. The transmit queue is filled from the bus side and drained by the serial engine. The receive queue is filled by the serial engine and drained from the bus side. Each queue compares its fill level with a programmable 4-bit threshold and raises a DMA request. The request can be gated per direction, so a DMA controller can move bursts of up to 16 samples through one data port.

The block keeps two sticky error flags. One records a transmit underrun, when the serial engine pulls from an empty transmit queue. The other records a receive overrun, when the serial engine pushes into a full receive queue. During an underrun the transmit output either sends silence or repeats the last sample that was sent, selected by a play-last control. A flush empties both queues before a stream starts. A soft reset also restores the thresholds, clears the flags and forgets the last sample. Nothing moves unless the global enable is high. A single interrupt line combines four separately enabled causes.

Top module: `audio_fifo_dma`

## Requirements
- R1: After `rst_ni` is released, both levels are 0, both flags are 0, the transmit threshold is 8 and the receive threshold is 7.
- R2: Each queue returns samples in the order they were accepted and holds up to 32 entries. A transmit write while the transmit queue is full is dropped. `rx_rdata_o` shows the oldest receive entry, or 0 when the queue is empty. A pop and a push in the same cycle are judged on the level before that edge.
- R3: `tx_dma_req_o` is high exactly when `enable_i` and `tx_dma_en_i` are high and the transmit level is less than or equal to the transmit threshold.
- R4: `rx_dma_req_o` is high exactly when `enable_i` and `rx_dma_en_i` are high, the receive level is nonzero, and the receive level is greater than or equal to the receive threshold.
- R5: A cycle with `thr_we_i` high loads `tx_thr_i` and `rx_thr_i` into the two thresholds; the new values take effect from the next cycle.
- R6: `tx_pull_i` while the transmit queue is empty sets `tx_ur_o` and leaves the level unchanged. With `play_last_i` low, `tx_sample_o` is 0 while the queue is empty.
- R7: With `play_last_i` high, `tx_sample_o` shows the most recently pulled sample while the transmit queue is empty.
- R8: `rx_push_i` while the receive queue holds 32 entries sets `rx_or_o` and drops the incoming sample.
- R9: The flags stay set until `ur_clr_i` or `or_clr_i` clears them. A set and a clear in the same cycle leave the flag set.
- R10: `flush_i` empties both queues and blocks all pushes and pops in that cycle. It leaves the flags, the thresholds and the last sample unchanged.
- R11: `soft_rst_i` empties both queues, clears both flags and the last sample, and restores thresholds 8 and 7. It takes priority over `thr_we_i`.
- R12: While `enable_i` is low, no push, pop or pull has any effect, no flag is set, and both DMA requests and both service causes are low.
- R13: `irq_o` is the OR of four terms, each ANDed with its own enable: `tx_ur_o`, `rx_or_o`, the transmit service condition (the R3 condition without the DMA gate), and the receive service condition (the R4 condition without the DMA gate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global enable |
| soft_rst_i | input | 1 | Synchronous soft reset of queues, flags and thresholds |
| flush_i | input | 1 | Empty both queues |
| thr_we_i | input | 1 | Load both thresholds |
| tx_thr_i | input | 4 | New transmit threshold |
| rx_thr_i | input | 4 | New receive threshold |
| play_last_i | input | 1 | Repeat the last sample during an underrun |
| tx_dma_en_i | input | 1 | Transmit DMA request gate |
| rx_dma_en_i | input | 1 | Receive DMA request gate |
| tx_ur_ie_i | input | 1 | Interrupt enable for underrun |
| rx_or_ie_i | input | 1 | Interrupt enable for overrun |
| tx_svc_ie_i | input | 1 | Interrupt enable for transmit service |
| rx_svc_ie_i | input | 1 | Interrupt enable for receive service |
| ur_clr_i | input | 1 | Clear the underrun flag |
| or_clr_i | input | 1 | Clear the overrun flag |
| tx_wr_i | input | 1 | Bus write into the transmit queue |
| tx_wdata_i | input | 16 | Bus write data |
| rx_rd_i | input | 1 | Bus read from the receive queue |
| rx_rdata_o | output | 16 | Oldest receive entry |
| tx_pull_i | input | 1 | Serial engine takes one transmit sample |
| tx_sample_o | output | 16 | Sample offered to the serial engine |
| rx_push_i | input | 1 | Serial engine delivers one receive sample |
| rx_sample_i | input | 16 | Delivered receive sample |
| tx_level_o | output | 6 | Transmit fill level |
| rx_level_o | output | 6 | Receive fill level |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_ur_o | output | 1 | Sticky underrun flag |
| rx_or_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that every input is stable at each rising edge. They also assume that flush, soft reset and the flag clears are single-cycle pulses issued only after reset is released. The bench drives every input on the falling edge and holds it through the next rising edge. It pulses flush and soft reset only outside reset. This keeps the stimulus inside those assumptions. Full, empty and simultaneous set-and-clear conditions are created on purpose, so the properties are exercised at the edges of the level range.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
  localparam int unsigned THR_W      = 4;
  localparam int unsigned TX_THR_DEF = 8;
  localparam int unsigned RX_THR_DEF = 7;

  typedef struct packed {
    logic [THR_W-1:0] tx;
    logic [THR_W-1:0] rx;
  } thr_cfg_t;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign level_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/fifo_req_gen.sv
module fifo_req_gen #(
  parameter int unsigned LW    = 6,
  parameter int unsigned THR_W = 4,
  parameter bit          IS_TX = 1'b1
) (
  input  logic [LW-1:0]    level_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             enable_i,
  input  logic             dma_en_i,
  output logic             svc_o,
  output logic             req_o
);
  logic [LW-1:0] thr_ext;
  logic          cond;

  assign thr_ext = LW'(thr_i);

  generate
    if (IS_TX) begin : g_tx
      assign cond = (level_i <= thr_ext);
    end else begin : g_rx
      assign cond = (level_i >= thr_ext) && (level_i != '0);
    end
  endgenerate

  assign svc_o = enable_i & cond;
  assign req_o = svc_o & dma_en_i;
endmodule

// File: rtl/audio_fifo_dma.sv
module audio_fifo_dma #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 16,
  localparam int unsigned LW   = $clog2(DEPTH + 1),
  localparam int unsigned TW   = audio_fifo_pkg::THR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          soft_rst_i,
  input  logic          flush_i,
  input  logic          thr_we_i,
  input  logic [TW-1:0] tx_thr_i,
  input  logic [TW-1:0] rx_thr_i,
  input  logic          play_last_i,
  input  logic          tx_dma_en_i,
  input  logic          rx_dma_en_i,
  input  logic          tx_ur_ie_i,
  input  logic          rx_or_ie_i,
  input  logic          tx_svc_ie_i,
  input  logic          rx_svc_ie_i,
  input  logic          ur_clr_i,
  input  logic          or_clr_i,
  input  logic          tx_wr_i,
  input  logic [DW-1:0] tx_wdata_i,
  input  logic          rx_rd_i,
  output logic [DW-1:0] rx_rdata_o,
  input  logic          tx_pull_i,
  output logic [DW-1:0] tx_sample_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_sample_i,
  output logic [LW-1:0] tx_level_o,
  output logic [LW-1:0] rx_level_o,
  output logic          tx_dma_req_o,
  output logic          rx_dma_req_o,
  output logic          tx_ur_o,
  output logic          rx_or_o,
  output logic          irq_o
);
  import audio_fifo_pkg::*;

  thr_cfg_t      thr_q;
  logic          act, clr;
  logic [DW-1:0] tx_head, rx_head, last_q;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          ur_q, or_q, ur_set, or_set;
  logic          tx_svc, rx_svc;

  assign act = enable_i & ~soft_rst_i & ~flush_i;
  assign clr = soft_rst_i | flush_i;

  sample_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(clr),
    .push_i(act & tx_wr_i), .din_i(tx_wdata_i),
    .pop_i(act & tx_pull_i), .head_o(tx_head),
    .level_o(tx_level_o), .full_o(tx_full), .empty_o(tx_empty)
  );

  sample_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(clr),
    .push_i(act & rx_push_i), .din_i(rx_sample_i),
    .pop_i(act & rx_rd_i), .head_o(rx_head),
    .level_o(rx_level_o), .full_o(rx_full), .empty_o(rx_empty)
  );

  fifo_req_gen #(.LW(LW), .THR_W(TW), .IS_TX(1'b1)) u_tx_req (
    .level_i(tx_level_o), .thr_i(thr_q.tx), .enable_i,
    .dma_en_i(tx_dma_en_i), .svc_o(tx_svc), .req_o(tx_dma_req_o)
  );

  fifo_req_gen #(.LW(LW), .THR_W(TW), .IS_TX(1'b0)) u_rx_req (
    .level_i(rx_level_o), .thr_i(thr_q.rx), .enable_i,
    .dma_en_i(rx_dma_en_i), .svc_o(rx_svc), .req_o(rx_dma_req_o)
  );

  assign ur_set = act & tx_pull_i & tx_empty;
  assign or_set = act & rx_push_i & rx_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= '{tx: TW'(TX_THR_DEF), rx: TW'(RX_THR_DEF)};
      ur_q   <= 1'b0;
      or_q   <= 1'b0;
      last_q <= '0;
    end else if (soft_rst_i) begin
      thr_q  <= '{tx: TW'(TX_THR_DEF), rx: TW'(RX_THR_DEF)};
      ur_q   <= 1'b0;
      or_q   <= 1'b0;
      last_q <= '0;
    end else begin
      if (thr_we_i) thr_q <= '{tx: tx_thr_i, rx: rx_thr_i};
      // set wins over clear
      if (ur_set)        ur_q <= 1'b1;
      else if (ur_clr_i) ur_q <= 1'b0;
      if (or_set)        or_q <= 1'b1;
      else if (or_clr_i) or_q <= 1'b0;
      if (act && tx_pull_i && !tx_empty) last_q <= tx_head;
    end
  end

  assign tx_sample_o = !tx_empty   ? tx_head :
                       play_last_i ? last_q  : '0;
  assign rx_rdata_o  = rx_empty ? '0 : rx_head;
  assign tx_ur_o     = ur_q;
  assign rx_or_o     = or_q;
  assign irq_o       = (ur_q & tx_ur_ie_i) | (or_q & rx_or_ie_i) |
                       (tx_svc & tx_svc_ie_i) | (rx_svc & rx_svc_ie_i);
endmodule

// File: rtl/audio_fifo_dma_chk.sv
module audio_fifo_dma_chk #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enable_i,
  input logic          soft_rst_i,
  input logic          flush_i,
  input logic          tx_dma_en_i,
  input logic          ur_clr_i,
  input logic          or_clr_i,
  input logic          tx_pull_i,
  input logic          rx_push_i,
  input logic [LW-1:0] tx_level_o,
  input logic [LW-1:0] rx_level_o,
  input logic          tx_dma_req_o,
  input logic          rx_dma_req_o,
  input logic          tx_ur_o,
  input logic          rx_or_o
);
  a_r2_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_o <= LW'(DEPTH)) && (rx_level_o <= LW'(DEPTH)));

  a_r3_tx_req_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_req_o |-> (enable_i && tx_dma_en_i));

  a_r4_rx_req_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_req_o |-> (rx_level_o != '0));

  a_r6_ur_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ur_o) |-> $past(enable_i && tx_pull_i && tx_level_o == '0));

  a_r8_or_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_or_o) |-> $past(enable_i && rx_push_i && rx_level_o == LW'(DEPTH)));

  a_r9_ur_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ur_o && !ur_clr_i && !soft_rst_i) |=> tx_ur_o);

  a_r9_or_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_or_o && !or_clr_i && !soft_rst_i) |=> rx_or_o);

  a_r10_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (tx_level_o == '0) && (rx_level_o == '0));

  a_r12_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !flush_i && !soft_rst_i) |=> ($stable(tx_level_o) && $stable(rx_level_o)));
endmodule

bind audio_fifo_dma audio_fifo_dma_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .soft_rst_i(soft_rst_i),
  .flush_i(flush_i), .tx_dma_en_i(tx_dma_en_i), .ur_clr_i(ur_clr_i),
  .or_clr_i(or_clr_i), .tx_pull_i(tx_pull_i), .rx_push_i(rx_push_i),
  .tx_level_o(tx_level_o), .rx_level_o(rx_level_o), .tx_dma_req_o(tx_dma_req_o),
  .rx_dma_req_o(rx_dma_req_o), .tx_ur_o(tx_ur_o), .rx_or_o(rx_or_o)
);

// File: tb/audio_fifo_dma_tb_top.sv
module audio_fifo_dma_tb_top;
  localparam int DEPTH = 32;
  localparam int DW    = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i, soft_rst_i, flush_i, thr_we_i, play_last_i;
  logic [3:0] tx_thr_i, rx_thr_i;
  logic tx_dma_en_i, rx_dma_en_i, tx_ur_ie_i, rx_or_ie_i, tx_svc_ie_i, rx_svc_ie_i;
  logic ur_clr_i, or_clr_i, tx_wr_i, rx_rd_i, tx_pull_i, rx_push_i;
  logic [DW-1:0] tx_wdata_i, rx_sample_i, rx_rdata_o, tx_sample_o;
  logic [LW-1:0] tx_level_o, rx_level_o;
  logic tx_dma_req_o, rx_dma_req_o, tx_ur_o, rx_or_o, irq_o;

  always #4 clk_i = ~clk_i;

  audio_fifo_dma #(.DEPTH(DEPTH), .DW(DW)) dut_i (.*);

  int txq[$];
  int rxq[$];
  int m_last, m_txthr, m_rxthr;
  bit m_ur, m_or;
  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    txq.delete(); rxq.delete();
    m_last = 0; m_ur = 0; m_or = 0; m_txthr = 8; m_rxthr = 7;
  endtask

  task automatic model_update();
    bit act, tx_e, tx_f, rx_e, rx_f, urs, ors;
    act = enable_i && !soft_rst_i && !flush_i;
    if (soft_rst_i) begin
      model_reset();
      return;
    end
    if (flush_i) begin txq.delete(); rxq.delete(); end
    if (thr_we_i) begin m_txthr = int'(tx_thr_i); m_rxthr = int'(rx_thr_i); end
    urs = 0; ors = 0;
    if (act) begin
      tx_e = txq.size() == 0; tx_f = txq.size() == DEPTH;
      rx_e = rxq.size() == 0; rx_f = rxq.size() == DEPTH;
      if (tx_pull_i) begin
        if (tx_e) urs = 1; else m_last = txq.pop_front();
      end
      if (tx_wr_i && !tx_f) txq.push_back(int'(tx_wdata_i));
      if (rx_rd_i && !rx_e) void'(rxq.pop_front());
      if (rx_push_i) begin
        if (rx_f) ors = 1; else rxq.push_back(int'(rx_sample_i));
      end
    end
    if (urs) m_ur = 1; else if (ur_clr_i) m_ur = 0;
    if (ors) m_or = 1; else if (or_clr_i) m_or = 0;
  endtask

  task automatic compare();
    int tl, rl, ts;
    bit tsvc, rsvc, irq;
    tl = txq.size(); rl = rxq.size();
    tsvc = enable_i && (tl <= m_txthr);
    rsvc = enable_i && (rl >= m_rxthr) && (rl != 0);
    ts = (tl != 0) ? txq[0] : (play_last_i ? m_last : 0);
    irq = (m_ur && tx_ur_ie_i) || (m_or && rx_or_ie_i) ||
          (tsvc && tx_svc_ie_i) || (rsvc && rx_svc_ie_i);
    chk("tx_level", int'(tx_level_o), tl);
    chk("rx_level", int'(rx_level_o), rl);
    chk("tx_sample", int'(tx_sample_o), ts);
    chk("rx_rdata", int'(rx_rdata_o), (rl != 0) ? rxq[0] : 0);
    chk("tx_dma_req", int'(tx_dma_req_o), int'(tsvc && tx_dma_en_i));
    chk("rx_dma_req", int'(rx_dma_req_o), int'(rsvc && rx_dma_en_i));
    chk("tx_ur", int'(tx_ur_o), int'(m_ur));
    chk("rx_or", int'(rx_or_o), int'(m_or));
    chk("irq", int'(irq_o), int'(irq));
  endtask

  task automatic clear_pulses();
    soft_rst_i = 0; flush_i = 0; thr_we_i = 0; ur_clr_i = 0; or_clr_i = 0;
    tx_wr_i = 0; rx_rd_i = 0; tx_pull_i = 0; rx_push_i = 0;
  endtask

  task automatic step();
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    compare();
    clear_pulses();
  endtask

  task automatic push_tx(int n, int base);
    for (int i = 0; i < n; i++) begin
      tx_wr_i = 1; tx_wdata_i = DW'(base + i); step();
    end
  endtask

  task automatic push_rx(int n, int base);
    for (int i = 0; i < n; i++) begin
      rx_push_i = 1; rx_sample_i = DW'(base + i); step();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clear_pulses();
    enable_i = 1; play_last_i = 0; tx_thr_i = 0; rx_thr_i = 0;
    tx_dma_en_i = 1; rx_dma_en_i = 1;
    tx_ur_ie_i = 0; rx_or_ie_i = 0; tx_svc_ie_i = 0; rx_svc_ie_i = 0;
    tx_wdata_i = 0; rx_sample_i = 0;
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1: reset state
    cur_req = "R1"; compare(); step();

    // R2 / R3: fill tx across default threshold 8, then drain in order
    cur_req = "R3"; push_tx(10, 100);
    cur_req = "R2"; repeat (10) begin tx_pull_i = 1; step(); end

    // R5: new thresholds
    cur_req = "R5"; thr_we_i = 1; tx_thr_i = 3; rx_thr_i = 12; step();
    push_tx(5, 200);
    cur_req = "R4"; push_rx(13, 300);
    repeat (2) begin rx_rd_i = 1; step(); end

    // R2: full tx, extra write dropped, simultaneous push/pop
    cur_req = "R2"; push_tx(27, 400); push_tx(2, 900);
    tx_wr_i = 1; tx_pull_i = 1; tx_wdata_i = 16'h0abc; step();
    repeat (32) begin tx_pull_i = 1; step(); end

    // R6: underrun with silence
    cur_req = "R6"; tx_pull_i = 1; step(); step();
    // R7: play-last repeats last pulled sample
    cur_req = "R7"; play_last_i = 1; step(); tx_pull_i = 1; step();
    // R9: clear, then set and clear in the same cycle
    cur_req = "R9"; ur_clr_i = 1; step();
    tx_pull_i = 1; ur_clr_i = 1; step();
    ur_clr_i = 1; step();

    // R8: receive overrun
    cur_req = "R8"; push_rx(DEPTH - 11, 500); push_rx(2, 1000);
    rx_push_i = 1; rx_rd_i = 1; rx_sample_i = 16'h1234; step();
    cur_req = "R9"; or_clr_i = 1; step();
    cur_req = "R2"; repeat (8) begin rx_rd_i = 1; step(); end

    // R13: each interrupt cause alone
    cur_req = "R13"; tx_pull_i = 1; push_rx(1, 1200);
    tx_ur_ie_i = 1; step(); tx_ur_ie_i = 0; rx_or_ie_i = 1; step();
    rx_or_ie_i = 0; tx_svc_ie_i = 1; step();
    tx_svc_ie_i = 0; rx_svc_ie_i = 1; step();
    tx_dma_en_i = 0; rx_dma_en_i = 0; step();
    tx_dma_en_i = 1; rx_dma_en_i = 1; tx_ur_ie_i = 1; rx_or_ie_i = 1; tx_svc_ie_i = 1;

    // R12: disabled block ignores all traffic
    cur_req = "R12"; enable_i = 0; step();
    tx_wr_i = 1; rx_push_i = 1; rx_rd_i = 1; tx_pull_i = 1; step();
    push_tx(3, 1300); enable_i = 1; step();

    // R10: flush keeps flags and thresholds
    cur_req = "R10"; push_tx(4, 1400);
    flush_i = 1; tx_wr_i = 1; rx_push_i = 1; step(); step();
    push_tx(2, 1500);

    // R11: soft reset beats threshold write
    cur_req = "R11"; soft_rst_i = 1; thr_we_i = 1; tx_thr_i = 1; rx_thr_i = 1; step();
    push_tx(9, 1600); push_rx(7, 1700); step();

    finish_run();
  end
endmodule